// File: doc/BRIEF.md
# NTT Control-Flow Integrity Sequencer

This block is the control path of a pipelined radix-2 number theoretic transform engine of 256 points. On an accepted start it loads a 4-bit rotating status register. Every enable that the engine's memory-read, arithmetic and memory-write stages use is taken from one bit of that register or from its inverse. The register rotates right by one place per running cycle, with bit 0 wrapping into bit 3. With the default seed the engine therefore sees a repeating four-cycle pattern: read, arithmetic, write, idle.

A second rotating register is loaded with the same seed. It shares no logic with the status register apart from the run qualifier. Its third most significant bit is compared every running cycle with the read enable that the datapath reports back. A clock cycle counter holds the length of the transform, which is log2(256)*128 butterfly cycles plus a pipeline fill of 4, 1028 cycles in all. It flags a finish that comes too early and a run that reaches the last cycle without finishing.

Both checks run beside the datapath and add no cycles to the transform. The alarms stay set until the next accepted start, and a 2-bit cause code summarises them.

Top module: `ntt_cfi_seq`

## Requirements
- R1: After reset, all enables, done_o, both alarms and cause_o are 0, and rd_port_sel_o is 1.
- R2: Start is accepted only when no run is active. The first running cycle is the cycle after the accepting edge. With seed 4'b0010, the running cycles repeat this order: rd_en_o high (cycle 1), ar_en_o high (cycle 2), wr_en_o high (cycle 3), all three low (cycle 4), then rd_en_o high again in cycle 5. At most one of the three enables is high in any cycle.
- R3: The enables come from the status register: rd_en_o = bit 1, ar_en_o = bit 0, wr_en_o = bit 3, and rd_port_sel_o = inverse of bit 3. The register rotates right once per running cycle, bit 0 into bit 3, and is cleared when a run ends, so all enables are low while idle.
- R4: If rd_en_i differs from bit 1 of the monitor register during a running cycle, cf_alarm_o is high from the next cycle on.
- R5: A run ends validly when done_i is high in running cycle 1028. done_o is then high for exactly the next cycle, and tm_alarm_o stays 0.
- R6: done_i high in any running cycle before 1028 ends the run. In the next cycle tm_alarm_o is set and done_o pulses.
- R7: If running cycle 1028 passes with done_i low, the run ends. In the next cycle tm_alarm_o is set and done_o pulses.
- R8: cause_o is {tm_alarm_o, cf_alarm_o}: 2'b01 for control flow, 2'b10 for timing, 2'b11 for both, 2'b00 for none.
- R9: Both alarms stay set until the next accepted start, which clears them at its accepting edge.
- R10: start_i while a run is active has no effect. Neither the cycle count nor the enable pattern restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start a transform |
| rd_en_i | input | 1 | Read enable as observed on the datapath side |
| done_i | input | 1 | Datapath finish indication |
| rd_en_o | output | 1 | Memory-read stage enable |
| ar_en_o | output | 1 | Arithmetic stage enable |
| wr_en_o | output | 1 | Memory-write stage enable |
| rd_port_sel_o | output | 1 | Memory port address select, 1 = read pointer |
| done_o | output | 1 | One-cycle pulse when a run ends |
| cf_alarm_o | output | 1 | Sticky control-flow violation |
| tm_alarm_o | output | 1 | Sticky timing violation |
| cause_o | output | 2 | Fault cause code |

## Verification
The enables are valid in the cycle after the accepting edge, and the bench samples them at the falling edge of each numbered running cycle. Each alarm is registered, so a mismatch or a bad finish in running cycle k shows up at the falling edge of cycle k+1. The bench checks that the alarm is still clear at cycle k and set one edge later. Valid, early, truncated-by-one and missing finishes are placed on exact running-cycle numbers counted from the start edge. The valid finish at cycle 1028 after an ignored start is what shows that the counter did not restart.

// File: rtl/ntt_cfi_pkg.sv
package ntt_cfi_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_CF   = 2'b01,
    CAUSE_TM   = 2'b10,
    CAUSE_BOTH = 2'b11
  } cause_e;

  function automatic cause_e make_cause(input logic tm, input logic cf);
    return cause_e'({tm, cf});
  endfunction

endpackage

// File: rtl/ntt_ctrl_csr.sv
module ntt_ctrl_csr #(
  parameter int                CTRL_W = 4,
  parameter logic [CTRL_W-1:0] SEED   = 4'b0010,
  parameter int                RD_BIT = 1,
  parameter int                AR_BIT = 0,
  parameter int                WR_BIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic shift_i,
  input  logic clear_i,
  output logic rd_en_o,
  output logic ar_en_o,
  output logic wr_en_o,
  output logic rd_port_sel_o
);

  logic [CTRL_W-1:0] csr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       csr_q <= '0;
    else if (load_i)   csr_q <= SEED;
    else if (clear_i)  csr_q <= '0;
    else if (shift_i)  csr_q <= {csr_q[0], csr_q[CTRL_W-1:1]};
  end

  assign rd_en_o       = csr_q[RD_BIT];
  assign ar_en_o       = csr_q[AR_BIT];
  assign wr_en_o       = csr_q[WR_BIT];
  assign rd_port_sel_o = ~csr_q[WR_BIT];

endmodule

// File: rtl/ntt_cfi_shadow.sv
module ntt_cfi_shadow #(
  parameter int                CTRL_W = 4,
  parameter logic [CTRL_W-1:0] SEED   = 4'b0010,
  parameter int                TAP    = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic active_i,
  input  logic obs_i,
  output logic fault_o
);

  logic [CTRL_W-1:0] shd_q;

  // free-running replay of the expected pattern, no link to the status register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        shd_q <= '0;
    else if (load_i)    shd_q <= SEED;
    else if (active_i)  shd_q <= {shd_q[0], shd_q[CTRL_W-1:1]};
  end

  assign fault_o = active_i && (shd_q[TAP] != obs_i);

endmodule

// File: rtl/ntt_cyc_watch.sv
module ntt_cyc_watch #(
  parameter int EXP_CYC = 1028,
  parameter int CNT_W   = $clog2(EXP_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             active_i,
  input  logic             done_i,
  output logic             fin_o,
  output logic             fault_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(EXP_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= CNT_W'(1);
    else if (active_i && !at_last)  cnt_q <= cnt_q + 1'b1;
  end

  assign fin_o   = active_i && (done_i || at_last);
  // early finish or a missing finish at the last cycle
  assign fault_o = active_i && (done_i ^ at_last);
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/ntt_cfi_seq.sv
module ntt_cfi_seq #(
  parameter int                N_PTS      = 256,
  parameter int                PIPE_DEPTH = 5,
  parameter int                CTRL_W     = 4,
  parameter logic [CTRL_W-1:0] SEED       = 4'b0010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rd_en_i,
  input  logic       done_i,
  output logic       rd_en_o,
  output logic       ar_en_o,
  output logic       wr_en_o,
  output logic       rd_port_sel_o,
  output logic       done_o,
  output logic       cf_alarm_o,
  output logic       tm_alarm_o,
  output logic [1:0] cause_o
);
  import ntt_cfi_pkg::*;

  localparam int EXP_CYC = $clog2(N_PTS) * (N_PTS / 2) + PIPE_DEPTH - 1;
  localparam int CNT_W   = $clog2(EXP_CYC + 1);
  localparam int RD_BIT  = CTRL_W - 3;
  localparam int AR_BIT  = 0;
  localparam int WR_BIT  = CTRL_W - 1;

  logic             run_q, done_q, cf_q, tm_q;
  logic             start_acc, fin, cf_fault, tm_fault;
  logic [CNT_W-1:0] cnt_w;

  assign start_acc = start_i && !run_q;

  ntt_ctrl_csr #(
    .CTRL_W(CTRL_W), .SEED(SEED),
    .RD_BIT(RD_BIT), .AR_BIT(AR_BIT), .WR_BIT(WR_BIT)
  ) u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start_acc),
    .shift_i      (run_q),
    .clear_i      (fin),
    .rd_en_o      (rd_en_o),
    .ar_en_o      (ar_en_o),
    .wr_en_o      (wr_en_o),
    .rd_port_sel_o(rd_port_sel_o)
  );

  ntt_cfi_shadow #(
    .CTRL_W(CTRL_W), .SEED(SEED), .TAP(RD_BIT)
  ) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_acc),
    .active_i(run_q),
    .obs_i   (rd_en_i),
    .fault_o (cf_fault)
  );

  ntt_cyc_watch #(
    .EXP_CYC(EXP_CYC), .CNT_W(CNT_W)
  ) u_watch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_acc),
    .active_i(run_q),
    .done_i  (done_i),
    .fin_o   (fin),
    .fault_o (tm_fault),
    .cnt_o   (cnt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cf_q   <= 1'b0;
      tm_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (start_acc) begin
        run_q <= 1'b1;
        cf_q  <= 1'b0;
        tm_q  <= 1'b0;
      end else begin
        if (fin) run_q <= 1'b0;
        cf_q <= cf_q | cf_fault;
        tm_q <= tm_q | tm_fault;
      end
    end
  end

  assign done_o     = done_q;
  assign cf_alarm_o = cf_q;
  assign tm_alarm_o = tm_q;
  assign cause_o    = make_cause(tm_q, cf_q);

endmodule

module ntt_cfi_seq_chk #(
  parameter int EXP_CYC = 1028,
  parameter int CNT_W   = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_i,
  input logic             rd_en_o,
  input logic             ar_en_o,
  input logic             wr_en_o,
  input logic             done_o,
  input logic             cf_alarm_o,
  input logic             tm_alarm_o,
  input logic [1:0]       cause_o,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_w
);

  a_r2_onehot_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_o, ar_en_o, wr_en_o}));

  a_r2_read_then_arith: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && run_q && !done_i && cnt_w != CNT_W'(EXP_CYC)) |=> ar_en_o);

  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !(rd_en_o || ar_en_o || wr_en_o));

  a_r4_cf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_alarm_o && !start_i) |=> cf_alarm_o);

  a_r9_tm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tm_alarm_o && !start_i) |=> tm_alarm_o);

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_w == CNT_W'(EXP_CYC)) |=> (!run_q && done_o));

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && start_i && !done_i && cnt_w != CNT_W'(EXP_CYC)) |=> (run_q && cnt_w == $past(cnt_w) + 1'b1));

  a_r8_cause_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o == 2'b00) |-> !(cf_alarm_o || tm_alarm_o));

endmodule

bind ntt_cfi_seq ntt_cfi_seq_chk #(.EXP_CYC(EXP_CYC), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_i    (done_i),
  .rd_en_o   (rd_en_o),
  .ar_en_o   (ar_en_o),
  .wr_en_o   (wr_en_o),
  .done_o    (done_o),
  .cf_alarm_o(cf_alarm_o),
  .tm_alarm_o(tm_alarm_o),
  .cause_o   (cause_o),
  .run_q     (run_q),
  .cnt_w     (cnt_w)
);

// File: tb/ntt_cfi_seq_tb.sv
`timescale 1ns/1ps
module ntt_cfi_seq_tb;

  localparam int LAST = 1028;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       flip = 1'b0;
  logic       done_in = 1'b0;
  logic       rd_en, ar_en, wr_en, sel, done_out, cf_al, tm_al;
  logic [1:0] cause;
  logic       rd_obs;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  assign rd_obs = rd_en ^ flip;

  ntt_cfi_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_en_i(rd_obs), .done_i(done_in),
    .rd_en_o(rd_en), .ar_en_o(ar_en), .wr_en_o(wr_en), .rd_port_sel_o(sel),
    .done_o(done_out), .cf_alarm_o(cf_al), .tm_alarm_o(tm_al), .cause_o(cause)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  // leaves the bench at the falling edge of running cycle 1
  task automatic begin_run();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // called in running cycle k; returns at the falling edge after the end edge
  task automatic finish_now();
    done_in = 1'b1;
    @(negedge clk);
    done_in = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 enables", {5'd0, rd_en, ar_en, wr_en}, 8'h0);
    chk("R1 sel", {7'd0, sel}, 8'h1);
    chk("R1 done", {7'd0, done_out}, 8'h0);
    chk("R1 cause", {6'd0, cause}, 8'h0);
  endtask

  task automatic t_sequence();
    begin_run();
    for (int k = 1; k <= 8; k++) begin
      logic [3:0] e;
      case ((k - 1) % 4)
        0: e = 4'b1001;
        1: e = 4'b0101;
        2: e = 4'b0010;
        default: e = 4'b0001;
      endcase
      chk($sformatf("R2 R3 pattern cycle %0d", k), {4'd0, rd_en, ar_en, wr_en, sel}, {4'd0, e});
      adv(1);
    end
    adv(LAST - 9);
    finish_now();
    chk("R5 done pulse", {7'd0, done_out}, 8'h1);
    chk("R5 no timing alarm", {6'd0, cause}, 8'h0);
    chk("R3 idle enables", {4'd0, rd_en, ar_en, wr_en, sel}, 8'h1);
    adv(1);
    chk("R5 done one cycle", {7'd0, done_out}, 8'h0);
  endtask

  task automatic t_cf();
    begin_run();
    adv(9);
    flip = 1'b1;
    chk("R4 not yet", {7'd0, cf_al}, 8'h0);
    @(negedge clk);
    flip = 1'b0;
    chk("R4 cf alarm", {7'd0, cf_al}, 8'h1);
    chk("R8 cause cf", {6'd0, cause}, 8'h1);
    adv(LAST - 11);
    finish_now();
    chk("R9 cf sticky", {6'd0, cause}, 8'h1);
    chk("R5 done after cf", {7'd0, done_out}, 8'h1);
  endtask

  task automatic t_cf_idle_slot();
    begin_run();
    adv(3);
    flip = 1'b1;  // read pulse injected in the idle slot
    @(negedge clk);
    flip = 1'b0;
    chk("R4 cf extra read", {7'd0, cf_al}, 8'h1);
    adv(LAST - 5);
    finish_now();
  endtask

  task automatic t_early(input int k);
    begin_run();
    adv(k - 1);
    chk("R6 before early done", {7'd0, tm_al}, 8'h0);
    finish_now();
    chk($sformatf("R6 early done at %0d", k), {6'd0, cause}, 8'h2);
    chk("R6 done pulse", {7'd0, done_out}, 8'h1);
    adv(3);
    chk("R9 tm sticky", {7'd0, tm_al}, 8'h1);
    chk("R6 run ended", {5'd0, rd_en, ar_en, wr_en}, 8'h0);
  endtask

  task automatic t_late();
    begin_run();
    adv(LAST - 1);
    chk("R7 not yet", {7'd0, tm_al}, 8'h0);
    @(negedge clk);
    chk("R7 late alarm", {6'd0, cause}, 8'h2);
    chk("R7 done pulse", {7'd0, done_out}, 8'h1);
  endtask

  task automatic t_both();
    begin_run();
    chk("R9 cleared by start", {6'd0, cause}, 8'h0);
    adv(4);
    flip = 1'b1;
    @(negedge clk);
    flip = 1'b0;
    adv(20);
    finish_now();
    chk("R8 cause both", {6'd0, cause}, 8'h3);
  endtask

  task automatic t_start_ignored();
    begin_run();
    adv(301);
    start = 1'b1;  // running cycle 302
    @(negedge clk);
    start = 1'b0;
    chk("R10 pattern kept", {5'd0, rd_en, ar_en, wr_en}, 8'h1);
    adv(LAST - 303);
    finish_now();
    chk("R10 count kept", {6'd0, cause}, 8'h0);
    chk("R10 done", {7'd0, done_out}, 8'h1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    adv(3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    adv(2);
    t_reset();
    t_sequence();
    adv(2);
    t_cf();
    adv(2);
    t_cf_idle_slot();
    adv(2);
    t_early(500);
    adv(2);
    t_early(LAST - 1);
    adv(2);
    t_late();
    adv(2);
    t_both();
    adv(2);
    t_start_ignored();
    adv(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule